// File: doc/BRIEF.md
# SD Host Register Compatibility Bridge

This block sits between a host that expects the standard SD host controller register layout and a controller core whose registers are all 32 bits wide, some of them rearranged. The host issues byte, halfword or word reads and writes at standard offsets. The bridge turns them into 32-bit cycles on the core port and reshapes the data where the two layouts disagree.

Narrow writes become a read-modify-write of the aligned core word. The transfer-mode halfword is held back in a shadow register and goes out in the same word as the next command write. Present-state levels, the DMA-select field of host control, the capability flags and the version halfword are remapped on reads. Writes that the core cannot take are filtered or dropped. A static input picks the byte order of the core port.

Each access is a one-cycle request pulse while the bridge is idle. The bridge then holds busy until a one-cycle done pulse, and read data is valid during that pulse.

Top module: `sd_reg_bridge`

## Requirements
- R1: Access size encoding is 0 = byte, 1 = halfword, 2 = word (3 acts as word). Every access targets the core word at the host address with bits 1:0 cleared. A halfword uses lane address[1] (shift 16 × address[1]) and a byte uses lane address[1:0] (shift 8 × lane). A narrow write leaves every other lane of the word unchanged, and a narrow read returns the selected lane zero-extended.
- R2: A narrow write that needs merging asserts coreRe for one cycle, then coreWe for one cycle, then hostDone for one cycle. From the request edge, done comes 3 cycles later for a merged write, 2 for a read or a direct word/command write, and 1 for a write with no core access. coreRe and coreWe are never high together. Out of reset busy, done, coreRe and coreWe are all low.
- R3: A halfword write to offset 0x0C (transfer mode) updates only the shadow register and makes no core access.
- R4: A halfword write to offset 0x0E (command) writes core word 0x0C as {command, shadow}, with the command in bits 31:16 and the shadow in bits 15:0. The shadow is zero after reset.
- R5: A word read of offset 0x24 (present state) returns core bits 19:0 unchanged, core bits 27:24 in bits 23:20, core bit 23 in bit 24, and zero in bits 31:25.
- R6: A byte read of offset 0x28 (host control) takes bits 4:3 from core bits 9:8. A byte write there moves the value's bits 4:3 to core bits 9:8, keeps core bits 4:3, writes the other low-byte bits from the value and clears the reserved mask (default bits 0 and 2).
- R7: When cfgNonStdHostCtl is high, byte writes to offset 0x28 make no core access.
- R8: Byte writes to offset 0x29 (power control) make no core access and leave the core word unchanged.
- R9: A halfword write to offset 0x04 (block size) forces core bits 14:12 to zero.
- R10: A word write to offset 0x34 (interrupt enable) always sets bit 2 (block-gap event enable).
- R11: A word read of offset 0x40 (capabilities) also sets bit 19 when bit 20 is set and cfgVendorVer is above 0x12.
- R12: A halfword read of offset 0xFE (version) returns the low half of core word 0xFC. When cfgFixedVersion is high it returns 0x1301 (vendor 0x13, specification 2.00) instead.
- R13: With cfgBigEndian high, the core word is byte-reversed on both core data paths, and all remapping works on the reversed (logical) word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgBigEndian | input | 1 | Static core byte-order select |
| cfgVendorVer | input | 8 | Vendor version of the core |
| cfgFixedVersion | input | 1 | Replace version read with fixed value |
| cfgNonStdHostCtl | input | 1 | Drop host-control byte writes |
| hostReq | input | 1 | Request pulse, sampled while idle |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostSize | input | 2 | Access size code |
| hostAddr | input | ADDR_W | Standard register byte offset |
| hostWdata | input | 32 | Write value, right-aligned |
| hostBusy | output | 1 | Access in progress |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Read result, valid with hostDone |
| coreAddr | output | ADDR_W | Aligned core word address |
| coreRe | output | 1 | Core read strobe |
| coreWe | output | 1 | Core write strobe |
| coreWdata | output | 32 | Core write word |
| coreRdata | input | 32 | Core read word, combinational from coreAddr |

## Verification
The bench aims at the deferred transfer-mode write. A bridge that forwarded it would show an extra core write and a command word with the wrong low half, and a shadow not cleared at reset would corrupt the first command. It drives lane merges on both halves and on interior bytes, where a wrong shift would damage neighbouring lanes. It also checks the host-control field swap with the reserved-bit clear, the dropped power and non-standard host-control writes, and the block-size bit clear. Word-level remaps are checked with both settings of the vendor threshold and the version override, and the byte-reversed core port is checked on both merge and read paths. Completion latency is measured on every access, so a missing or extra core cycle shows up as a timing failure.

// File: rtl/sdbr_pkg.sv
package sdbr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;
    logic captureOld;
    logic coreRe;
    logic coreWe;
    logic done;
  } ctrlStrobe_t;

  // what an access needs from the core
  typedef struct packed {
    logic needRead;
    logic needWrite;
  } accClass_t;

  localparam int OFF_BLKSZ   = 'h04;
  localparam int OFF_XFER    = 'h0C;
  localparam int OFF_CMD     = 'h0E;
  localparam int OFF_PRESENT = 'h24;
  localparam int OFF_HOSTCTL = 'h28;
  localparam int OFF_POWER   = 'h29;
  localparam int OFF_INTEN   = 'h34;
  localparam int OFF_CAPS    = 'h40;
  localparam int OFF_VERSION = 'hFE;

  function automatic logic [31:0] byteSwap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/sdbr_ctrl.sv
module sdbr_ctrl
  import sdbr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostReq,
  input  accClass_t   liveCls,
  output ctrlStrobe_t strb,
  output logic        hostBusy
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} state_e;

  state_e stateQ, stateD;
  logic   needWrQ;
  logic   needRdQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (hostReq) begin
          if (liveCls.needRead)       stateD = ST_READ;
          else if (liveCls.needWrite) stateD = ST_WRITE;
          else                        stateD = ST_DONE;
        end
      end
      ST_READ:  stateD = needWrQ ? ST_WRITE : ST_DONE;
      ST_WRITE: stateD = ST_DONE;
      ST_DONE:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      needWrQ <= 1'b0;
      needRdQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE && hostReq) begin
        needWrQ <= liveCls.needWrite;
        needRdQ <= liveCls.needRead;
      end
    end
  end

  always_comb begin
    strb.captureReq = (stateQ == ST_IDLE) && hostReq;
    strb.captureOld = (stateQ == ST_READ);
    strb.coreRe     = (stateQ == ST_READ);
    strb.coreWe     = (stateQ == ST_WRITE);
    strb.done       = (stateQ == ST_DONE);
  end

  assign hostBusy = (stateQ != ST_IDLE);

  assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.coreRe && strb.coreWe));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !strb.done);

  assert_read_before_merge_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.coreWe && needRdQ) |-> $past(strb.coreRe));

endmodule

// File: rtl/sdbr_datapath.sv
module sdbr_datapath
  import sdbr_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter logic [31:0] HC_RSVD_MASK = 32'h0000_0005,
  parameter logic [7:0]  ADMA2_VENDOR = 8'h12,
  parameter logic [15:0] FIXED_VER    = 16'h1301
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              cfgBigEndian,
  input  logic [7:0]        cfgVendorVer,
  input  logic              cfgFixedVersion,
  input  logic              cfgNonStdHostCtl,
  input  logic              hostWe,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output accClass_t         liveCls,
  output logic [31:0]       hostRdata,
  output logic [ADDR_W-1:0] coreAddr,
  output logic [31:0]       coreWdata,
  input  logic [31:0]       coreRdata
);

  localparam logic [ADDR_W-1:0] A_BLKSZ   = ADDR_W'(OFF_BLKSZ);
  localparam logic [ADDR_W-1:0] A_XFER    = ADDR_W'(OFF_XFER);
  localparam logic [ADDR_W-1:0] A_CMD     = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_PRESENT = ADDR_W'(OFF_PRESENT);
  localparam logic [ADDR_W-1:0] A_HOSTCTL = ADDR_W'(OFF_HOSTCTL);
  localparam logic [ADDR_W-1:0] A_POWER   = ADDR_W'(OFF_POWER);
  localparam logic [ADDR_W-1:0] A_INTEN   = ADDR_W'(OFF_INTEN);
  localparam logic [ADDR_W-1:0] A_CAPS    = ADDR_W'(OFF_CAPS);
  localparam logic [ADDR_W-1:0] A_VERSION = ADDR_W'(OFF_VERSION);
  localparam logic [7:0]        DMA_SEL   = 8'h18;
  localparam int                DMA_LIFT  = 5;

  logic              reqWe;
  logic [1:0]        reqSize;
  logic [ADDR_W-1:0] reqAddr;
  logic [31:0]       reqWdata;
  logic [31:0]       oldRaw;
  logic [15:0]       shadowXfer;

  // classify the live request so control can choose its path
  always_comb begin
    liveCls = '{needRead: 1'b1, needWrite: 1'b1};
    if (!hostWe) begin
      liveCls = '{needRead: 1'b1, needWrite: 1'b0};
    end else if (hostSize == SZ_HALF) begin
      if (hostAddr == A_XFER)     liveCls = '{needRead: 1'b0, needWrite: 1'b0};
      else if (hostAddr == A_CMD) liveCls = '{needRead: 1'b0, needWrite: 1'b1};
    end else if (hostSize == SZ_BYTE) begin
      if (hostAddr == A_POWER ||
          (hostAddr == A_HOSTCTL && cfgNonStdHostCtl))
        liveCls = '{needRead: 1'b0, needWrite: 1'b0};
    end else begin
      liveCls = '{needRead: 1'b0, needWrite: 1'b1};
    end
  end

  logic liveXfer;
  assign liveXfer = hostWe && hostSize == SZ_HALF && hostAddr == A_XFER;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqWe      <= 1'b0;
      reqSize    <= SZ_WORD;
      reqAddr    <= '0;
      reqWdata   <= '0;
      oldRaw     <= '0;
      shadowXfer <= '0;
    end else begin
      if (strb.captureReq) begin
        reqWe    <= hostWe;
        reqSize  <= hostSize;
        reqAddr  <= hostAddr;
        reqWdata <= hostWdata;
        if (liveXfer) shadowXfer <= hostWdata[15:0];
      end
      if (strb.captureOld) oldRaw <= coreRdata;
    end
  end

  logic [31:0] oldL;
  logic [4:0]  halfSh;
  logic [4:0]  byteSh;
  logic [31:0] wrL;
  logic [31:0] rdL;
  logic [31:0] laneWord;
  logic [7:0]  hcByte;

  assign oldL     = cfgBigEndian ? byteSwap(oldRaw) : oldRaw;
  assign halfSh   = {reqAddr[1], 4'b0000};
  assign byteSh   = {reqAddr[1:0], 3'b000};
  assign laneWord = oldL >> ((reqSize == SZ_HALF) ? halfSh : byteSh);

  // write side remap
  always_comb begin
    wrL = reqWdata;
    if (reqSize == SZ_HALF) begin
      if (reqAddr == A_CMD) begin
        wrL = {reqWdata[15:0], shadowXfer};
      end else begin
        wrL = (oldL & ~(32'h0000_FFFF << halfSh)) |
              ({16'h0000, reqWdata[15:0]} << halfSh);
        if (reqAddr == A_BLKSZ) wrL[14:12] = 3'b000;
      end
    end else if (reqSize == SZ_BYTE) begin
      if (reqAddr == A_HOSTCTL) begin
        wrL = (oldL & ~({24'h0, DMA_SEL} << DMA_LIFT)) |
              ({24'h0, reqWdata[7:0] & DMA_SEL} << DMA_LIFT);
        wrL[7:0] = (reqWdata[7:0] & ~DMA_SEL) | (oldL[7:0] & DMA_SEL);
        wrL = wrL & ~HC_RSVD_MASK;
      end else begin
        wrL = (oldL & ~(32'h0000_00FF << byteSh)) |
              ({24'h0, reqWdata[7:0]} << byteSh);
      end
    end else if (reqAddr == A_INTEN) begin
      wrL = reqWdata | 32'h0000_0004;
    end
  end

  // read side remap
  always_comb begin
    rdL    = oldL;
    hcByte = laneWord[7:0];
    if (reqSize == SZ_HALF) begin
      if (reqAddr == A_VERSION)
        rdL = {16'h0000, cfgFixedVersion ? FIXED_VER : oldL[15:0]};
      else
        rdL = {16'h0000, laneWord[15:0]};
    end else if (reqSize == SZ_BYTE) begin
      if (reqAddr == A_HOSTCTL)
        hcByte = (laneWord[7:0] & ~DMA_SEL) | (oldL[12:5] & DMA_SEL);
      rdL = {24'h0, hcByte};
    end else if (reqAddr == A_PRESENT) begin
      rdL = {7'b0, oldL[23], oldL[27:24], oldL[19:0]};
    end else if (reqAddr == A_CAPS) begin
      if (oldL[20] && cfgVendorVer > ADMA2_VENDOR) rdL = oldL | 32'h0008_0000;
    end
  end

  assign hostRdata = rdL;
  assign coreAddr  = {reqAddr[ADDR_W-1:2], 2'b00};
  assign coreWdata = cfgBigEndian ? byteSwap(wrL) : wrL;

  logic [31:0] outL;
  assign outL = cfgBigEndian ? byteSwap(coreWdata) : coreWdata;

  assert_xfer_no_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.coreWe |-> !(reqWe && reqSize == SZ_HALF && reqAddr == A_XFER));

  assert_cmd_carries_shadow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.coreWe && reqSize == SZ_HALF && reqAddr == A_CMD) |-> outL[15:0] == shadowXfer);

  assert_nonstd_hc_dropped_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.coreWe && cfgNonStdHostCtl) |-> !(reqSize == SZ_BYTE && reqAddr == A_HOSTCTL));

  assert_power_dropped_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.coreWe |-> !(reqSize == SZ_BYTE && reqAddr == A_POWER));

  assert_blksz_boundary_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.coreWe && reqSize == SZ_HALF && reqAddr == A_BLKSZ) |-> outL[14:12] == 3'b000);

  assert_inten_gap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.coreWe && reqSize[1] && reqAddr == A_INTEN) |-> outL[2]);

endmodule

// File: rtl/sd_reg_bridge.sv
module sd_reg_bridge
  import sdbr_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter logic [31:0] HC_RSVD_MASK = 32'h0000_0005
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgBigEndian,
  input  logic [7:0]        cfgVendorVer,
  input  logic              cfgFixedVersion,
  input  logic              cfgNonStdHostCtl,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic              hostBusy,
  output logic              hostDone,
  output logic [31:0]       hostRdata,
  output logic [ADDR_W-1:0] coreAddr,
  output logic              coreRe,
  output logic              coreWe,
  output logic [31:0]       coreWdata,
  input  logic [31:0]       coreRdata
);

  ctrlStrobe_t strb;
  accClass_t   liveCls;

  sdbr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .liveCls  (liveCls),
    .strb     (strb),
    .hostBusy (hostBusy)
  );

  sdbr_datapath #(
    .ADDR_W       (ADDR_W),
    .HC_RSVD_MASK (HC_RSVD_MASK)
  ) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .strb             (strb),
    .cfgBigEndian     (cfgBigEndian),
    .cfgVendorVer     (cfgVendorVer),
    .cfgFixedVersion  (cfgFixedVersion),
    .cfgNonStdHostCtl (cfgNonStdHostCtl),
    .hostWe           (hostWe),
    .hostSize         (hostSize),
    .hostAddr         (hostAddr),
    .hostWdata        (hostWdata),
    .liveCls          (liveCls),
    .hostRdata        (hostRdata),
    .coreAddr         (coreAddr),
    .coreWdata        (coreWdata),
    .coreRdata        (coreRdata)
  );

  assign hostDone = strb.done;
  assign coreRe   = strb.coreRe;
  assign coreWe   = strb.coreWe;

endmodule

// File: tb/sd_reg_bridge_test.sv
`timescale 1ns/1ps
module sd_reg_bridge_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgBigEndian = 1'b0;
  logic [7:0]  cfgVendorVer = 8'h13;
  logic        cfgFixedVersion = 1'b0;
  logic        cfgNonStdHostCtl = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostSize = 2'd0;
  logic [7:0]  hostAddr = 8'h00;
  logic [31:0] hostWdata = 32'h0;
  logic        hostBusy, hostDone;
  logic [31:0] hostRdata;
  logic [7:0]  coreAddr;
  logic        coreRe, coreWe;
  logic [31:0] coreWdata;
  logic [31:0] coreRdata;

  always #2 clk = ~clk;

  sd_reg_bridge uut (
    .clk(clk), .rstN(rstN), .cfgBigEndian(cfgBigEndian), .cfgVendorVer(cfgVendorVer),
    .cfgFixedVersion(cfgFixedVersion), .cfgNonStdHostCtl(cfgNonStdHostCtl),
    .hostReq(hostReq), .hostWe(hostWe), .hostSize(hostSize), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostBusy(hostBusy), .hostDone(hostDone), .hostRdata(hostRdata),
    .coreAddr(coreAddr), .coreRe(coreRe), .coreWe(coreWe), .coreWdata(coreWdata),
    .coreRdata(coreRdata)
  );

  // core register file model
  logic [31:0] mem [64];
  logic        ldEn = 1'b0;
  logic [5:0]  ldIdx = '0;
  logic [31:0] ldVal = '0;
  int          coreWeCnt = 0;

  assign coreRdata = mem[coreAddr[7:2]];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'h0;
    end else if (ldEn) begin
      mem[ldIdx] <= ldVal;
    end else if (coreWe) begin
      mem[coreAddr[7:2]] <= coreWdata;
    end
    if (coreWe) coreWeCnt <= coreWeCnt + 1;
  end

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard for read data
  logic [31:0] expQ[$];
  string       tagQ[$];

  always @(negedge clk) begin
    if (hostDone && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(hostRdata == e, t, hostRdata, e);
    end
  end

  task automatic preload(input int idx, input logic [31:0] v);
    @(negedge clk);
    ldEn = 1'b1; ldIdx = idx[5:0]; ldVal = v;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic doOp(input logic we, input logic [1:0] sz, input logic [7:0] a,
                      input logic [31:0] wd, input int expLat, input int expWe, input string tag);
    int lat;
    int we0;
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostSize = sz; hostAddr = a; hostWdata = wd;
    we0 = coreWeCnt;
    @(negedge clk);
    hostReq = 1'b0;
    lat = 1;
    while (!hostDone && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == expLat, {tag, " latency R2"}, lat, expLat);
    chk((coreWeCnt - we0) == expWe, {tag, " core writes R2"}, coreWeCnt - we0, expWe);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    doOp(1'b0, sz, a, 32'h0, 2, 0, tag);
  endtask

  task automatic chkMem(input int idx, input logic [31:0] exp, input string tag);
    chk(mem[idx] == exp, tag, mem[idx], exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(!hostBusy && !hostDone, "R2 reset handshake idle", {30'b0, hostBusy, hostDone}, 0);
    chk(!coreRe && !coreWe, "R2 reset core strobes", {30'b0, coreRe, coreWe}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 command with shadow fresh from reset, R3 transfer mode deferred
    doOp(1'b1, 2'd1, 8'h0E, 32'h1A2B, 2, 1, "R4 command after reset");
    chkMem(3, 32'h1A2B_0000, "R4 shadow zero after reset");
    doOp(1'b1, 2'd1, 8'h0C, 32'h0033, 1, 0, "R3 transfer mode");
    chkMem(3, 32'h1A2B_0000, "R3 transfer mode not written");
    doOp(1'b1, 2'd1, 8'h0E, 32'h0C01, 2, 1, "R4 command");
    chkMem(3, 32'h0C01_0033, "R4 command plus shadow");

    // R1 lane merges and reads
    preload(2, 32'hA5A5_5A5A);
    doOp(1'b1, 2'd1, 8'h0A, 32'h1234, 3, 1, "R1 upper half merge");
    chkMem(2, 32'h1234_5A5A, "R1 upper half merge data");
    doOp(1'b1, 2'd0, 8'h09, 32'h77, 3, 1, "R1 byte1 merge");
    chkMem(2, 32'h1234_775A, "R1 byte1 merge data");
    rd(2'd0, 8'h0B, 32'h12, "R1 byte3 read");
    rd(2'd1, 8'h08, 32'h775A, "R1 lower half read");

    // R5 present state
    preload(9, 32'hA581_2345);
    rd(2'd2, 8'h24, 32'h0151_2345, "R5 present state remap");

    // R6 host control
    preload(10, 32'h1200_03E7);
    rd(2'd0, 8'h28, 32'hFF, "R6 host control read");
    doOp(1'b1, 2'd0, 8'h28, 32'h17, 3, 1, "R6 host control write");
    chkMem(10, 32'h1200_0202, "R6 host control write data");

    // R7 non-standard host control
    cfgNonStdHostCtl = 1'b1;
    doOp(1'b1, 2'd0, 8'h28, 32'hFF, 1, 0, "R7 host control dropped");
    chkMem(10, 32'h1200_0202, "R7 host control unchanged");
    cfgNonStdHostCtl = 1'b0;

    // R8 power control
    doOp(1'b1, 2'd0, 8'h29, 32'h55, 1, 0, "R8 power ignored");
    chkMem(10, 32'h1200_0202, "R8 power word unchanged");

    // R9 block size, R1 upper lane untouched by clear
    doOp(1'b1, 2'd1, 8'h04, 32'hFFFF, 3, 1, "R9 block size");
    chkMem(1, 32'h0000_8FFF, "R9 boundary bits cleared");
    doOp(1'b1, 2'd1, 8'h06, 32'h7777, 3, 1, "R1 block count lane");
    chkMem(1, 32'h7777_8FFF, "R1 block count lane data");

    // R10 interrupt enable
    doOp(1'b1, 2'd2, 8'h34, 32'h0, 2, 1, "R10 interrupt enable");
    chkMem(13, 32'h0000_0004, "R10 block gap forced");
    preload(14, 32'hFFFF_FFFF);
    doOp(1'b1, 2'd2, 8'h38, 32'h0, 2, 1, "R10 other word plain");
    chkMem(14, 32'h0000_0000, "R10 other word plain data");

    // R11 capabilities
    preload(16, 32'h0010_0000);
    rd(2'd2, 8'h40, 32'h0018_0000, "R11 ADMA2 added");
    cfgVendorVer = 8'h12;
    rd(2'd2, 8'h40, 32'h0010_0000, "R11 vendor at threshold");
    cfgVendorVer = 8'h13;

    // R12 version
    preload(63, 32'hBEEF_0302);
    rd(2'd1, 8'hFE, 32'h0302, "R12 version low half");
    cfgFixedVersion = 1'b1;
    rd(2'd1, 8'hFE, 32'h1301, "R12 fixed version");
    rd(2'd1, 8'hFC, 32'h0302, "R12 neighbour half unaffected");
    cfgFixedVersion = 1'b0;

    // R13 byte order
    cfgBigEndian = 1'b1;
    doOp(1'b1, 2'd2, 8'h38, 32'h1122_3344, 2, 1, "R13 word write");
    chkMem(14, 32'h4433_2211, "R13 word byte reversed");
    rd(2'd0, 8'h39, 32'h33, "R13 byte read");
    doOp(1'b1, 2'd1, 8'h3A, 32'hAABB, 3, 1, "R13 half merge");
    chkMem(14, 32'h4433_BBAA, "R13 half merge raw");
    rd(2'd2, 8'h38, 32'hAABB_3344, "R13 word read");
    cfgBigEndian = 1'b0;

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R2 every read completed", expQ.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog R2 actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule